// File: doc/BRIEF.md
# Multi-Context Circular Address Generator

This block produces memory addresses for a signal-processing datapath that keeps several independent ring buffers in one shared memory. Each context holds a base address, a length in elements, a step code that scales one element to 1, 2 or 4 addressable units, a bit-reverse enable, and a running element offset that acts as the pointer. Software sets up a context through a narrow configuration write port. During operation only the pointer changes.

An access request names a context. The generator returns that context's current address in the same cycle, with no register in the path. On the next clock edge it advances the pointer by one element. When the pointer passes the last element of the buffer, it returns to the first. In bit-reverse mode the element offset is mirrored over log2(length) bits before it is scaled and added to the base. This produces the reordered sequence that a radix-2 FFT needs. If the length is not a power of two, the mode flags an error.

Top module: `circ_agen`

## Requirements
- R1: While a context is selected on `acc_idx`, `acc_addr` equals base + offset × step in the same cycle, taken modulo 2^ADDR_W.
- R2: An access (`acc_req`=1) advances only the selected context's offset, by one element, at the next clock edge. Cycles with no access and no configuration write leave every pointer unchanged.
- R3: After the access at offset length−1, the offset returns to 0, so the next address is the base again.
- R4: The step code is held in `cfg_data[1:0]`. Code 0 gives a step of 1, code 1 gives 2, code 2 gives 4, and code 3 is treated as 4.
- R5: `cfg_sel` selects the field to write: 0 writes the base, 1 writes the length (`cfg_data[LEN_W-1:0]`), 2 writes the step code, and 3 writes the bit-reverse enable (`cfg_data[0]`). Writing the base also resets that context's offset to 0. Writes to the other three fields leave the pointer unchanged.
- R6: When bit-reverse is enabled and the length is 2^k, the address is base + reverse_k(offset) × step. The offset itself still advances linearly.
- R7: `acc_err` is 1 only during an access to a context that has bit-reverse enabled and a length that is not a power of two, including zero. In that case the address falls back to the linear form.
- R8: A context of length 0 keeps returning its base address.
- R9: After reset every context has base 0, length 0, step code 0, bit-reverse off and offset 0, so the address is 0 and `acc_err` is 0.
- R10: If a base write and an access hit the same context in one cycle, the address uses the configuration from before the write. The write wins for the pointer, so the next access returns the new base.
- R11: NUM_CTX contexts (8 by default) are kept fully independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Context written |
| cfg_sel | input | 2 | Field written: 0 base, 1 length, 2 step code, 3 bit-reverse enable |
| cfg_data | input | ADDR_W | Write data |
| acc_req | input | 1 | Access request; advances the pointer |
| acc_idx | input | IDX_W | Context accessed |
| acc_addr | output | ADDR_W | Current address of the selected context |
| acc_err | output | 1 | Bit-reverse requested on a length that is not a power of two |

## Verification
Unit-step, 2-unit and 4-unit buffers, the last using both codes 2 and 3, are run through a complete lap and past it. This separates correct scaling from a wrap that is off by one element. Accesses to two contexts are interleaved, with idle cycles and non-base writes placed between them, to show that only the addressed pointer moves. Bit-reverse sequences of lengths 8 and 4 tell mirroring over log2(length) bits apart from mirroring over the full offset width. A length of 6 and a length of 0 cover the error fallback and the degenerate buffer. A base write in the same cycle as an access on the same context checks which value wins.

// File: rtl/circ_agen_pkg.sv
// Shared definitions for the circular address generator.
package circ_agen_pkg;
    // Which context field a configuration write targets
    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_LEN  = 2'd1,
        CFG_STEP = 2'd2,
        CFG_MODE = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/circ_agen_ctx.sv
// One buffer context: stores base, length, step code, bit-reverse enable
// and the element offset (pointer). Assumes LEN_W <= ADDR_W.
module circ_agen_ctx
    import circ_agen_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cfg_sel_e          wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              adv,
    output logic [ADDR_W-1:0] base_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [1:0]        step_o,
    output logic              brev_o,
    output logic [LEN_W-1:0]  ptr_o
);
    logic [LEN_W:0]   inc;
    logic [LEN_W-1:0] ptr_next;

    // Next offset after one element, wrapping to zero at the buffer end
    always_comb begin
        inc      = {1'b0, ptr_o} + {{LEN_W{1'b0}}, 1'b1};
        ptr_next = (inc >= {1'b0, len_o}) ? '0 : inc[LEN_W-1:0];
    end

    // Configuration fields; a base write resets the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            len_o  <= '0;
            step_o <= '0;
            brev_o <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                CFG_BASE: base_o <= wr_data;
                CFG_LEN:  len_o  <= wr_data[LEN_W-1:0];
                CFG_STEP: step_o <= wr_data[1:0];
                CFG_MODE: brev_o <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // Pointer post-modify; a base write takes priority over an access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (wr_en && (wr_sel == CFG_BASE)) begin
            ptr_o <= '0;
        end else if (adv) begin
            ptr_o <= ptr_next;
        end
    end
endmodule

// File: rtl/circ_agen_map.sv
// Combinational address formation for the selected context: optional
// bit reversal of the offset over log2(length) bits, scaling by the step
// and addition of the base. Assumes offset < length.
module circ_agen_map #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [1:0]        step,
    input  logic              brev,
    input  logic [LEN_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr,
    output logic              err
);
    localparam int LG_W = $clog2(LEN_W + 1);

    logic              is_pow2;
    logic [LG_W-1:0]   lg;
    logic [LG_W:0]     rshift;
    logic [LEN_W-1:0]  rev_full;
    logic [LEN_W-1:0]  rev_off;
    logic [LEN_W-1:0]  off;
    logic [1:0]        shamt;

    // Power-of-two test and log2 of the length
    always_comb begin
        is_pow2 = (len != '0) && ((len & (len - 1'b1)) == '0);
        lg      = '0;
        for (int i = 0; i < LEN_W; i++) begin
            if (len[i]) lg = LG_W'(i);
        end
    end

    // Mirror the offset over the full width, then drop the unused low bits
    always_comb begin
        for (int i = 0; i < LEN_W; i++) begin
            rev_full[i] = ptr[LEN_W-1-i];
        end
        rshift  = (LG_W+1)'(LEN_W) - {1'b0, lg};
        rev_off = rev_full >> rshift;
    end

    // Final address and error flag
    always_comb begin
        off   = (brev && is_pow2) ? rev_off : ptr;
        shamt = (step == 2'd3) ? 2'd2 : step;
        addr  = base + (ADDR_W'(off) << shamt);
        err   = req && brev && !is_pow2;
    end
endmodule

// File: rtl/circ_agen.sv
// Top level: NUM_CTX independent circular buffer contexts with a shared
// configuration port and a single access port. The address is combinational
// from acc_idx; the pointer update lands on the next clock edge.
module circ_agen
    import circ_agen_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 8,
    parameter int NUM_CTX = 8,
    localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              acc_req,
    input  logic [IDX_W-1:0]  acc_idx,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_err
);
    logic [NUM_CTX-1:0][ADDR_W-1:0] ctx_base;
    logic [NUM_CTX-1:0][LEN_W-1:0]  ctx_len;
    logic [NUM_CTX-1:0][1:0]        ctx_step;
    logic [NUM_CTX-1:0]             ctx_brev;
    logic [NUM_CTX-1:0][LEN_W-1:0]  ctx_ptr;
    cfg_sel_e                       sel_e;

    assign sel_e = cfg_sel_e'(cfg_sel);

    // One storage context per buffer
    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        circ_agen_ctx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctx (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_idx == IDX_W'(g))),
            .wr_sel  (sel_e),
            .wr_data (cfg_data),
            .adv     (acc_req && (acc_idx == IDX_W'(g))),
            .base_o  (ctx_base[g]),
            .len_o   (ctx_len[g]),
            .step_o  (ctx_step[g]),
            .brev_o  (ctx_brev[g]),
            .ptr_o   (ctx_ptr[g])
        );
    end

    // Address computation for the context named by acc_idx
    circ_agen_map #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_map (
        .req  (acc_req),
        .base (ctx_base[acc_idx]),
        .len  (ctx_len[acc_idx]),
        .step (ctx_step[acc_idx]),
        .brev (ctx_brev[acc_idx]),
        .ptr  (ctx_ptr[acc_idx]),
        .addr (acc_addr),
        .err  (acc_err)
    );
endmodule

// File: rtl/circ_agen_chk.sv
// Property checker for circ_agen, attached through bind below.
module circ_agen_chk #(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 8,
    parameter int NUM_CTX = 8,
    parameter int IDX_W   = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [IDX_W-1:0]               cfg_idx,
    input logic [1:0]                     cfg_sel,
    input logic                           acc_req,
    input logic [IDX_W-1:0]               acc_idx,
    input logic [ADDR_W-1:0]              acc_addr,
    input logic                           acc_err,
    input logic [NUM_CTX-1:0][ADDR_W-1:0] ctx_base,
    input logic [NUM_CTX-1:0][LEN_W-1:0]  ctx_len,
    input logic [NUM_CTX-1:0]             ctx_brev,
    input logic [NUM_CTX-1:0][LEN_W-1:0]  ctx_ptr
);
    logic collide;
    assign collide = cfg_we && (cfg_idx == acc_idx);

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !collide &&
         ({1'b0, ctx_ptr[acc_idx]} + 1'b1) < {1'b0, ctx_len[acc_idx]})
        |=> ({1'b0, ctx_ptr[$past(acc_idx)]} ==
             {1'b0, $past(ctx_ptr[acc_idx])} + 1'b1));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !collide && ctx_len[acc_idx] != '0 &&
         ctx_ptr[acc_idx] == ctx_len[acc_idx] - 1'b1)
        |=> (ctx_ptr[$past(acc_idx)] == '0));

    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_req && !cfg_we) |=> $stable(ctx_ptr));

    a_r5_base_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd0) |=> (ctx_ptr[$past(cfg_idx)] == '0));

    a_r1_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_err && ctx_len[acc_idx] != '0)
        |-> ((acc_addr - ctx_base[acc_idx]) <
             (ADDR_W'(ctx_len[acc_idx]) << 2)));

    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_req && ctx_brev[acc_idx]));

    a_r7_pow2_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && $countones(ctx_len[acc_idx]) == 1) |-> !acc_err);
endmodule

bind circ_agen circ_agen_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_CTX(NUM_CTX), .IDX_W(IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_sel  (cfg_sel),
    .acc_req  (acc_req),
    .acc_idx  (acc_idx),
    .acc_addr (acc_addr),
    .acc_err  (acc_err),
    .ctx_base (ctx_base),
    .ctx_len  (ctx_len),
    .ctx_brev (ctx_brev),
    .ctx_ptr  (ctx_ptr)
);

// File: tb/sim_circ_agen.sv
// Directed bench for circ_agen: one task per scenario.
module sim_circ_agen;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [1:0]        cfg_sel = '0;
    logic [ADDR_W-1:0] cfg_data = '0;
    logic              acc_req = 1'b0;
    logic [IDX_W-1:0]  acc_idx = '0;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    circ_agen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .acc_req(acc_req),
        .acc_idx(acc_idx), .acc_addr(acc_addr), .acc_err(acc_err)
    );

    task automatic check(input string req, input int act_a, input int exp_a,
                         input bit act_e, input bit exp_e);
        checks++;
        if (act_a != exp_a || act_e != exp_e) begin
            errors++;
            $display("FAIL %s addr=%0h err=%0b expected addr=%0h err=%0b",
                     req, act_a, act_e, exp_a, exp_e);
        end
    endtask

    task automatic cfg_write(input int idx, input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx);
        cfg_sel = 2'(sel); cfg_data = ADDR_W'(data);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int idx, input int base, input int len,
                         input int step, input int mode);
        cfg_write(idx, 0, base);
        cfg_write(idx, 1, len);
        cfg_write(idx, 2, step);
        cfg_write(idx, 3, mode);
    endtask

    task automatic access(input int idx, input int exp_a, input bit exp_e,
                          input string req);
        @(negedge clk);
        acc_req = 1'b1; acc_idx = IDX_W'(idx);
        #1 check(req, int'(acc_addr), exp_a, acc_err, exp_e);
        @(posedge clk); #1;
        acc_req = 1'b0;
    endtask

    task automatic peek(input int idx, input int exp_a, input string req);
        @(negedge clk);
        acc_idx = IDX_W'(idx);
        #1 check(req, int'(acc_addr), exp_a, acc_err, 1'b0);
    endtask

    // R9: state after reset
    task automatic t_reset();
        peek(0, 0, "R9 reset ctx0");
        peek(7, 0, "R9 reset ctx7");
    endtask

    // R1/R2/R3: unit step lap and wrap
    task automatic t_linear();
        setup(1, 100, 5, 0, 0);
        for (int i = 0; i < 5; i++) access(1, 100 + i, 1'b0, "R1 R2 linear");
        access(1, 100, 1'b0, "R3 wrap to base");
    endtask

    // R4: step codes 1, 2, 3
    task automatic t_steps();
        setup(2, 200, 3, 1, 0);
        access(2, 200, 1'b0, "R4 step2");
        access(2, 202, 1'b0, "R4 step2");
        access(2, 204, 1'b0, "R4 step2");
        access(2, 200, 1'b0, "R3 R4 step2 wrap");
        setup(3, 'h300, 4, 2, 0);
        access(3, 'h300, 1'b0, "R4 step4");
        access(3, 'h304, 1'b0, "R4 step4");
        setup(4, 'h400, 3, 3, 0);
        access(4, 'h400, 1'b0, "R4 code3");
        access(4, 'h404, 1'b0, "R4 code3");
        access(4, 'h408, 1'b0, "R4 code3");
        access(4, 'h400, 1'b0, "R4 code3 wrap");
    endtask

    // R11/R2/R5: interleaving, idle cycles, non-base writes
    task automatic t_indep();
        access(2, 202, 1'b0, "R11 ctx2");
        access(1, 101, 1'b0, "R11 ctx1");
        access(2, 204, 1'b0, "R11 ctx2");
        access(1, 102, 1'b0, "R11 ctx1");
        repeat (3) @(posedge clk);
        peek(1, 103, "R2 idle hold");
        cfg_write(1, 1, 5);
        cfg_write(1, 2, 0);
        cfg_write(1, 3, 0);
        peek(1, 103, "R5 non-base write holds ptr");
    endtask

    // R5: base write resets the pointer
    task automatic t_base();
        cfg_write(1, 0, 150);
        access(1, 150, 1'b0, "R5 base reset");
        access(1, 151, 1'b0, "R5 after base");
    endtask

    // R10: base write and access on the same context together
    task automatic t_collide();
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_sel = 2'd0; cfg_data = 16'd500;
        acc_req = 1'b1; acc_idx = 3'd1;
        #1 check("R10 old config", int'(acc_addr), 152, acc_err, 1'b0);
        @(posedge clk); #1;
        cfg_we = 1'b0; acc_req = 1'b0;
        access(1, 500, 1'b0, "R10 write wins");
        access(1, 501, 1'b0, "R10 then advance");
    endtask

    // R6: bit-reversed sequences for lengths 8 and 4
    task automatic t_bitrev();
        int seq8[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
        int seq4[4] = '{0, 2, 1, 3};
        setup(5, 'h40, 8, 0, 1);
        for (int i = 0; i < 8; i++) access(5, 'h40 + seq8[i], 1'b0, "R6 rev8");
        access(5, 'h40, 1'b0, "R6 R3 rev8 wrap");
        setup(6, 'h80, 4, 1, 1);
        for (int i = 0; i < 4; i++) access(6, 'h80 + 2 * seq4[i], 1'b0, "R6 rev4 step2");
    endtask

    // R7: non power-of-two length in bit-reverse mode
    task automatic t_err();
        setup(7, 'h700, 6, 0, 1);
        access(7, 'h700, 1'b1, "R7 err linear");
        access(7, 'h701, 1'b1, "R7 err linear");
        peek(7, 'h702, "R7 no err without req");
    endtask

    // R8: zero length
    task automatic t_zero();
        setup(0, 10, 0, 0, 0);
        access(0, 10, 1'b0, "R8 zero len");
        access(0, 10, 1'b0, "R8 zero len");
        access(0, 10, 1'b0, "R8 zero len");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_linear();
        t_steps();
        t_indep();
        t_base();
        t_collide();
        t_bitrev();
        t_err();
        t_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule